// File: doc/BRIEF.md
# USB Device Interrupt Status Controller

This block keeps the event flags of a full-speed USB device's interrupt status word and derives the bus suspend and wake-up conditions from them. The serial interface engine sends it single-cycle event pulses: a finished transfer with its endpoint number and direction, a packet-memory overrun, and four kinds of protocol error. It also receives a bus-activity pulse, a bus-reset pulse and a force-suspend level that software drives.

Software reads the status word at all times. Through one write port it writes either the status word or an interrupt-enable mask. The four event flags are cleared by writing zero to them. Writing one to any of them changes nothing. The transfer flag ignores software writes and clears only when the endpoint logic consumes the event. An idle counter raises the suspend flag after a parameterised number of quiet clock cycles. During forced suspend, bus activity sets the wake-up flag and drives the wake-up line. In the same cycle, with no clock edge, it also drives a low-power-mode clear.

Top module: `usb_istat_ctrl`

## Requirements
- R1: A pulse on `ev_xfer_done` sets status bit 15 and records `ev_ep_num` in bits [EP_W-1:0] and `ev_dir_in` in bit EP_W. Software writes never change bit 15.
- R2: A `xfer_consume` pulse clears bit 15. If `ev_xfer_done` arrives in the same cycle, bit 15 stays set and the new endpoint number and direction are recorded.
- R3: A pulse on `ev_mem_overrun` sets status bit 14.
- R4: A pulse on any bit of `ev_proto_err` sets status bit 13. The bits are: 0 response timeout, 1 CRC error, 2 bit-stuff error, 3 framing violation.
- R5: A status write (`reg_wr`=1, `reg_sel`=0) clears each of bits 14..11 whose `reg_wdata` bit is 0. It leaves unchanged each of those bits whose `reg_wdata` bit is 1.
- R6: When a hardware set and a software clear reach the same flag in the same cycle, the flag ends up set.
- R7: No suspend flag is raised before the first `usb_reset`. After it, status bit 11 sets on the IDLE_CYCLES-th clock edge without `bus_activity`. Every activity pulse restarts the count.
- R8: While `force_susp` is 1, the idle count is held at zero and bit 11 is not raised.
- R9: `bus_activity` with `force_susp`=1 drives `lp_clear` high in the same cycle, combinationally. It also sets status bit 12 at the next edge. `wakeup` follows bit 12 until software clears it.
- R10: A mask write (`reg_wr`=1, `reg_sel`=1) stores `reg_wdata[15:11]` as enables for status bits 15..11. `irq` is the OR of each flag ANDed with its enable.
- R11: After reset, `status`, the mask, `irq` and `wakeup` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_xfer_done | input | 1 | Transfer completed pulse |
| ev_ep_num | input | EP_W | Endpoint of the completed transfer |
| ev_dir_in | input | 1 | Direction of the completed transfer |
| xfer_consume | input | 1 | Endpoint logic has consumed the transfer event |
| ev_mem_overrun | input | 1 | Packet-memory overrun or underrun pulse |
| ev_proto_err | input | 4 | Protocol error pulses (timeout, CRC, stuff, framing) |
| bus_activity | input | 1 | Traffic seen on the bus this cycle |
| usb_reset | input | 1 | Bus reset detected |
| force_susp | input | 1 | Software forced-suspend level |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the status word, 1 selects the mask |
| reg_wdata | input | 16 | Register write data |
| status | output | 16 | Status word |
| irq | output | 1 | Interrupt request |
| lp_clear | output | 1 | Clears low-power mode, combinational |
| wakeup | output | 1 | Wake-up line |

## Verification
A flag that is lost or sticks wrong shows up at the next clock edge in `status`. If that flag is enabled, `irq` shows it in the same cycle. A corrupt idle count shows only when suspend sets too early or too late, up to IDLE_CYCLES edges after the error. For that reason the bench counts the timeout edge by edge against its own model. A wrong wake-up path shows in `lp_clear` within the same cycle, and in `wakeup` one edge later.

// File: rtl/usb_istat_pkg.sv
package usb_istat_pkg;
   localparam int REG_W     = 16;
   localparam int BIT_XFER  = 15;
   localparam int BIT_OVR   = 14;
   localparam int BIT_ERR   = 13;
   localparam int BIT_WAKE  = 12;
   localparam int BIT_SUSP  = 11;
   localparam int FLAG_LO   = 11;
   localparam int N_FLAGS   = 5;
   localparam int N_W0C     = 4;
   localparam int N_ERR_SRC = 4;
   typedef enum logic {
      SEL_STATUS = 1'b0,
      SEL_MASK   = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/istat_w0c_flags.sv
module istat_w0c_flags #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] hw_set,
   input  logic         sw_wr,
   input  logic [N-1:0] sw_data,
   output logic [N-1:0] flags
);
   if (N < 1) begin : g_bad_n
      $error("istat_w0c_flags: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[i] <= 1'b0;
         else if (hw_set[i])
            flags[i] <= 1'b1;
         else if (sw_wr && !sw_data[i])
            flags[i] <= 1'b0;
      end

      assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
         hw_set[i] |=> flags[i]);
      assert_one_no_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (sw_wr && sw_data[i] && !hw_set[i]) |=> (flags[i] == $past(flags[i])));
      assert_zero_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (sw_wr && !sw_data[i] && !hw_set[i]) |=> !flags[i]);
   end
endmodule

// File: rtl/istat_idle_timer.sv
module istat_idle_timer #(
   parameter int LIMIT = 144000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic usb_reset,
   input  logic bus_activity,
   input  logic hold,
   output logic expire
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
   localparam logic [CW-1:0] TOP  = CW'(LIMIT);

   if (LIMIT < 2) begin : g_bad_limit
      $error("istat_idle_timer: LIMIT must be at least 2");
   end

   logic          armed;
   logic [CW-1:0] cnt;
   logic          run;

   assign run    = armed && !hold;
   assign expire = run && !usb_reset && !bus_activity && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (usb_reset) begin
         armed <= 1'b1;
         cnt   <= '0;
      end else if (bus_activity || !run) begin
         cnt   <= '0;
      end else if (cnt != TOP) begin
         cnt   <= cnt + 1'b1;
      end
   end

   assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= TOP);
   assert_hold_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !usb_reset) |=> (cnt == '0));
   assert_activity_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_activity |=> (cnt == '0));
endmodule

// File: rtl/istat_irq_merge.sv
module istat_irq_merge #(
   parameter int N          = 5,
   parameter bit REGISTERED = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] flags,
   input  logic [N-1:0] enables,
   output logic         irq
);
   logic hit;
   assign hit = |(flags & enables);

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= hit;
      end
   end else begin : g_comb
      assign irq = hit;
   end
endmodule

// File: rtl/usb_istat_ctrl.sv
module usb_istat_ctrl
   import usb_istat_pkg::*;
#(
   parameter int EP_W           = 4,
   parameter int IDLE_CYCLES    = 144000,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ev_xfer_done,
   input  logic [EP_W-1:0] ev_ep_num,
   input  logic            ev_dir_in,
   input  logic            xfer_consume,
   input  logic            ev_mem_overrun,
   input  logic [3:0]      ev_proto_err,
   input  logic            bus_activity,
   input  logic            usb_reset,
   input  logic            force_susp,
   input  logic            reg_wr,
   input  logic            reg_sel,
   input  logic [15:0]     reg_wdata,
   output logic [15:0]     status,
   output logic            irq,
   output logic            lp_clear,
   output logic            wakeup
);
   localparam int PAD_W = FLAG_LO - EP_W - 1;

   if (EP_W < 1 || EP_W > FLAG_LO - 1) begin : g_bad_ep
      $error("usb_istat_ctrl: EP_W must be between 1 and 10");
   end

   logic                xfer_q;
   logic [EP_W-1:0]     ep_q;
   logic                dir_q;
   logic [N_FLAGS-1:0]  mask_q;
   logic [N_W0C-1:0]    w0c_set;
   logic [N_W0C-1:0]    w0c_q;
   logic                wake_evt;
   logic                idle_expire;
   logic                stat_wr;
   logic [N_FLAGS-1:0]  flag_vec;

   assign stat_wr  = reg_wr && (reg_sel_e'(reg_sel) == SEL_STATUS);
   assign wake_evt = force_susp && bus_activity;
   assign lp_clear = wake_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xfer_q <= 1'b0;
         ep_q   <= '0;
         dir_q  <= 1'b0;
      end else if (ev_xfer_done) begin
         xfer_q <= 1'b1;
         ep_q   <= ev_ep_num;
         dir_q  <= ev_dir_in;
      end else if (xfer_consume) begin
         xfer_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '0;
      else if (reg_wr && (reg_sel_e'(reg_sel) == SEL_MASK))
         mask_q <= reg_wdata[BIT_XFER:FLAG_LO];
   end

   istat_idle_timer #(.LIMIT(IDLE_CYCLES)) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .usb_reset    (usb_reset),
      .bus_activity (bus_activity),
      .hold         (force_susp),
      .expire       (idle_expire)
   );

   assign w0c_set = {ev_mem_overrun, |ev_proto_err, wake_evt, idle_expire};

   istat_w0c_flags #(.N(N_W0C)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_set  (w0c_set),
      .sw_wr   (stat_wr),
      .sw_data (reg_wdata[BIT_OVR:FLAG_LO]),
      .flags   (w0c_q)
   );

   assign flag_vec = {xfer_q, w0c_q};

   istat_irq_merge #(.N(N_FLAGS), .REGISTERED(IRQ_REGISTERED)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags   (flag_vec),
      .enables (mask_q),
      .irq     (irq)
   );

   if (PAD_W > 0) begin : g_pad
      assign status = {flag_vec, {PAD_W{1'b0}}, dir_q, ep_q};
   end else begin : g_nopad
      assign status = {flag_vec, dir_q, ep_q};
   end

   assign wakeup = w0c_q[BIT_WAKE - FLAG_LO];

   assert_xfer_sw_proof_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (status[BIT_XFER] && !xfer_consume) |=> status[BIT_XFER]);
   assert_xfer_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_xfer_done |=> status[BIT_XFER]);
   assert_wake_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wakeup) |-> $past(force_susp && bus_activity));
   assert_wake_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wakeup && !(stat_wr && !reg_wdata[BIT_WAKE])) |=> wakeup);
   assert_susp_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (force_susp && !status[BIT_SUSP] && !(stat_wr && reg_wdata[BIT_SUSP])) |=> !status[BIT_SUSP]);
   if (!IRQ_REGISTERED) begin : g_irq_chk
      assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> |(status[BIT_XFER:FLAG_LO] & mask_q));
   end
endmodule

// File: tb/tb_usb_istat_ctrl.sv
`timescale 1ns/1ps
module tb_usb_istat_ctrl;
   localparam int EP_W = 4;
   localparam int IDLE = 20;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ev_xfer_done = 0, ev_dir_in = 0, xfer_consume = 0, ev_mem_overrun = 0;
   logic [EP_W-1:0] ev_ep_num = '0;
   logic [3:0]      ev_proto_err = '0;
   logic            bus_activity = 0, usb_reset = 0, force_susp = 0, reg_wr = 0, reg_sel = 0;
   logic [15:0]     reg_wdata = '0;
   logic [15:0]     status;
   logic            irq, lp_clear, wakeup;

   int total = 0;
   int bad = 0;
   bit done = 0;

   usb_istat_ctrl #(.EP_W(EP_W), .IDLE_CYCLES(IDLE), .IRQ_REGISTERED(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .ev_xfer_done(ev_xfer_done), .ev_ep_num(ev_ep_num),
      .ev_dir_in(ev_dir_in), .xfer_consume(xfer_consume), .ev_mem_overrun(ev_mem_overrun),
      .ev_proto_err(ev_proto_err), .bus_activity(bus_activity), .usb_reset(usb_reset),
      .force_susp(force_susp), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .status(status), .irq(irq), .lp_clear(lp_clear), .wakeup(wakeup)
   );

   always #10 clk = ~clk;

   // behavioural reference
   bit m_xfer, m_ovr, m_err, m_wake, m_susp, m_dir, m_armed;
   int m_ep, m_cnt;
   bit [4:0] m_mask;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_xfer = 0; m_ovr = 0; m_err = 0; m_wake = 0; m_susp = 0; m_dir = 0;
         m_armed = 0; m_ep = 0; m_cnt = 0; m_mask = '0;
      end else begin
         bit clr_ok, run, susp_hit;
         clr_ok = reg_wr && !reg_sel;
         run = m_armed && !force_susp;
         susp_hit = run && !usb_reset && !bus_activity && (m_cnt == IDLE - 1);
         if (ev_xfer_done) begin m_xfer = 1; m_ep = int'(ev_ep_num); m_dir = ev_dir_in; end
         else if (xfer_consume) m_xfer = 0;
         m_ovr  = ev_mem_overrun | (m_ovr && !(clr_ok && !reg_wdata[14]));
         m_err  = (ev_proto_err != 0) | (m_err && !(clr_ok && !reg_wdata[13]));
         m_wake = (force_susp && bus_activity) | (m_wake && !(clr_ok && !reg_wdata[12]));
         m_susp = susp_hit | (m_susp && !(clr_ok && !reg_wdata[11]));
         if (usb_reset) begin m_cnt = 0; m_armed = 1; end
         else if (bus_activity || !run) m_cnt = 0;
         else if (m_cnt < IDLE) m_cnt++;
         if (reg_wr && reg_sel) m_mask = reg_wdata[15:11];
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      bit [4:0] fl;
      fl = {m_xfer, m_ovr, m_err, m_wake, m_susp};
      chk("R1 xfer", 32'(status[15]), 32'(m_xfer));
      chk("R1 ep", 32'(status[3:0]), 32'(m_ep));
      chk("R1 dir", 32'(status[4]), 32'(m_dir));
      chk("R3 ovr", 32'(status[14]), 32'(m_ovr));
      chk("R4 err", 32'(status[13]), 32'(m_err));
      chk("R9 wake", 32'(status[12]), 32'(m_wake));
      chk("R7 susp", 32'(status[11]), 32'(m_susp));
      chk("R11 pad", 32'(status[10:5]), 32'd0);
      chk("R10 irq", 32'(irq), 32'(|(fl & m_mask)));
      chk("R9 wakeup", 32'(wakeup), 32'(m_wake));
      chk("R9 lp_clear", 32'(lp_clear), 32'(force_susp && bus_activity));
   endtask

   task automatic step();
      @(negedge clk);
      compare_all();
      ev_xfer_done = 0; xfer_consume = 0; ev_mem_overrun = 0; ev_proto_err = '0;
      bus_activity = 0; usb_reset = 0; reg_wr = 0;
   endtask

   task automatic wr(input bit sel, input logic [15:0] d);
      reg_wr = 1; reg_sel = sel; reg_wdata = d;
   endtask

   initial begin
      repeat (3) step();
      chk("R11 status", 32'(status), 32'd0);
      chk("R11 irq", 32'(irq), 32'd0);
      chk("R11 wakeup", 32'(wakeup), 32'd0);
      rst_n = 1;
      step();
      // no enables yet: flag set gives no irq
      ev_mem_overrun = 1; step();
      chk("R11 mask zero irq", 32'(irq), 32'd0);
      wr(0, 16'h0000); step();
      wr(1, 16'hF800); step();
      ev_xfer_done = 1; ev_ep_num = 4'd5; ev_dir_in = 1; step();
      chk("R1 set", 32'(status), 32'h8015);
      chk("R10 irq on", 32'(irq), 32'd1);
      wr(0, 16'h0000); step();
      chk("R1 sw write ignored", 32'(status[15]), 32'd1);
      xfer_consume = 1; ev_xfer_done = 1; ev_ep_num = 4'd3; ev_dir_in = 0; step();
      chk("R2 event beats consume", 32'(status), 32'h8003);
      xfer_consume = 1; step();
      chk("R2 consume clears", 32'(status[15]), 32'd0);
      ev_mem_overrun = 1; step();
      chk("R3 overrun", 32'(status[14]), 32'd1);
      wr(0, 16'hFFFF); step();
      chk("R5 one keeps", 32'(status[14]), 32'd1);
      wr(0, 16'hBFFF); step();
      chk("R5 zero clears", 32'(status[14]), 32'd0);
      for (int i = 0; i < 4; i++) begin
         ev_proto_err = 4'(1 << i); step();
         chk("R4 error source", 32'(status[13]), 32'd1);
         wr(0, 16'h0000); step();
      end
      ev_proto_err = 4'b0100; wr(0, 16'h0000); step();
      chk("R6 set beats clear", 32'(status[13]), 32'd1);
      wr(1, 16'h0000); step();
      chk("R10 masked", 32'(irq), 32'd0);
      wr(1, 16'h0800); step();
      wr(0, 16'h0000); step();
      repeat (30) step();
      chk("R7 no suspend before reset", 32'(status[11]), 32'd0);
      usb_reset = 1; step();
      repeat (IDLE - 1) step();
      chk("R7 not yet", 32'(status[11]), 32'd0);
      step();
      chk("R7 timeout", 32'(status[11]), 32'd1);
      chk("R10 susp irq", 32'(irq), 32'd1);
      wr(0, 16'h0000); step();
      repeat (5) step();
      bus_activity = 1; step();
      repeat (IDLE - 1) step();
      chk("R7 restarted", 32'(status[11]), 32'd0);
      step();
      chk("R7 after restart", 32'(status[11]), 32'd1);
      force_susp = 1; wr(0, 16'h0000); step();
      repeat (3 * IDLE) step();
      chk("R8 held", 32'(status[11]), 32'd0);
      @(negedge clk);
      compare_all();
      bus_activity = 1;
      #1 chk("R9 lp_clear same cycle", 32'(lp_clear), 32'd1);
      step();
      chk("R9 wake flag", 32'(status[12]), 32'd1);
      force_susp = 0;
      repeat (4) step();
      chk("R9 wakeup stays", 32'(wakeup), 32'd1);
      wr(0, 16'hEFFF); step();
      chk("R9 wakeup cleared", 32'(wakeup), 32'd0);
      bus_activity = 1; step();
      chk("R9 no wake unsuspended", 32'(status[12]), 32'd0);
      repeat (3) step();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule